// File: doc/BRIEF.md
# Double-Buffered Six-Channel Volume Register Bank

This block holds the gain settings for six audio output channels, grouped as three left/right pairs. A control agent writes 9-bit words on a 5-bit address. Each word carries a 7-bit attenuation code in 1 dB steps, a per-channel zero-cross enable and a commit flag. A write always lands first in the addressed channel's holding register. The active gains that drive the attenuators change only when a write has its commit flag set. That write copies all six holding registers into the active gains together, so the channels move in step.

A channel with zero-cross enabled does not apply its newly committed gain at once. The gain stays pending until a sample strobe shows that the sign of the channel's own audio sample differs from its previous sample. If no sign change arrives within a bounded number of strobes, the pending gain is forced through. The bank drives out the six active 7-bit gain codes. It also gives a combinational read port onto the holding registers.

Top module: `vol_bank`

## Requirements
- R1: After reset, every active gain is 127 (0 dB). Every holding register reads back 8'h7F: zero-cross enable (bit 7) is 0 and the code (bits 6:0) is 127.
- R2: A write with data bit 8 = 0 to address 0..5 stores data bits 7:0 in that channel's holding register. The read port shows the new value from the clock edge that takes the write. No active gain changes.
- R3: Address k (0..5) selects channel k in the order L1, R1, L2, R2, L3, R3. Channel k's active gain appears on gain_o[7k+6:7k], and its holding register reads back at rd_addr_i = k.
- R4: A write with data bit 8 = 1 to address 0..5 first stores that write's bits 7:0. At the same clock edge, it copies every channel's holding code into the channel's active gain. This applies to each channel whose zero-cross enable is 0.
- R5: The commit flag is not stored. A later write with bit 8 = 0 leaves every active gain unchanged.
- R6: When a channel's holding zero-cross enable is 1 at a commit, the committed code goes pending. It is applied at the first sample strobe whose sample sign bit (bit SW-1) differs from the sign seen at the channel's previous strobe. The value is visible in the cycle after that strobe. The sign is taken as 0 before the first strobe.
- R7: A pending code that sees no sign change is applied at the 1024th sample strobe after its commit.
- R8: Writes to addresses 6..31 are ignored, including any commit flag they carry. Reads of addresses 6..31 return 0.
- R9: A commit that arrives while a code is pending replaces the pending code with the newest holding value and restarts the 1024-strobe count.
- R10: A commit to a channel whose zero-cross enable is 0 applies immediately and cancels any pending code on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 9 | Write data: bit 8 commit, bit 7 zero-cross enable, bits 6:0 code |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Holding register contents, 0 when unmapped |
| smp_stb_i | input | 1 | Sample strobe shared by all channels |
| smp_i | input | 96 | Six signed samples, channel k in bits 16k+15:16k |
| gain_o | output | 42 | Six active gain codes, channel k in bits 7k+6:7k |

## Verification
Writes, commits and strobes are all registered once. A holding value is due on the read port, and an immediate commit on gain_o, at the first clock edge after the request. A zero-cross or timeout update is due one edge after the strobe that releases it. The bench drives each request for exactly one cycle starting at a falling edge. It then samples every gain and all 32 read addresses at the next falling edge and compares them against a requirement-level model. That model is updated for the same operation. Strobe runs are checked after every strobe, so an update that comes one strobe early or late is seen. This is how the 1023rd and 1024th strobes of a timeout are told apart.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int CODE_W = 7;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 9;
  localparam logic [CODE_W-1:0] CODE_RST = '1;

  typedef struct packed {
    logic              zc;
    logic [CODE_W-1:0] code;
  } vol_reg_t;
endpackage

// File: rtl/vol_hold.sv
module vol_hold
  import vol_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  output vol_reg_t [NCH-1:0]    hold_nx_o,
  output logic                  commit_o
);
  vol_reg_t [NCH-1:0] hold_q;
  logic               hit;

  assign hit      = wr_en_i && (wr_addr_i < ADDR_W'(NCH));
  assign commit_o = hit && wr_data_i[8];

  // holding values as they stand after this cycle's write
  always_comb begin
    hold_nx_o = hold_q;
    if (hit) hold_nx_o[wr_addr_i] = vol_reg_t'(wr_data_i[7:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) hold_q[i] <= '{zc: 1'b0, code: CODE_RST};
    end else begin
      hold_q <= hold_nx_o;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NCH)) rd_data_o = hold_q[rd_addr_i];
  end

  p_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(NCH)) |=> $stable(hold_q));

  p_rd_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= ADDR_W'(NCH)) |-> (rd_data_o == 8'h00));
endmodule

// File: rtl/vol_chan.sv
module vol_chan
  import vol_pkg::*;
#(
  parameter int TMO = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  vol_reg_t          nxt_i,
  input  logic              stb_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] gain_o
);
  localparam int TW = $clog2(TMO) + 1;

  logic [CODE_W-1:0] gain_q, pcode_q;
  logic              pend_q, prev_q;
  logic [TW-1:0]     cnt_q;
  logic              flip, expire;

  assign flip   = sign_i != prev_q;
  assign expire = cnt_q == TW'(TMO - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q  <= CODE_RST;
      pcode_q <= CODE_RST;
      pend_q  <= 1'b0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (stb_i) prev_q <= sign_i;
      if (commit_i) begin
        if (nxt_i.zc) begin
          pend_q  <= 1'b1;
          pcode_q <= nxt_i.code;
          cnt_q   <= '0;
        end else begin
          gain_q <= nxt_i.code;
          pend_q <= 1'b0;
        end
      end else if (pend_q && stb_i) begin
        if (flip || expire) begin
          gain_q <= pcode_q;
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign gain_o = gain_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !pend_q) |=> $stable(gain_o));

  p_direct_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !nxt_i.zc) |=> (gain_o == $past(nxt_i.code)) && !pend_q);

  p_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && nxt_i.zc) |=> pend_q && $stable(gain_o));

  p_no_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !stb_i) |=> $stable(gain_o));

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(TMO - 1));
endmodule

// File: rtl/vol_bank.sv
module vol_bank
  import vol_pkg::*;
#(
  parameter int NCH = 6,
  parameter int SW  = 16,
  parameter int TMO = 1024
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  input  logic                  smp_stb_i,
  input  logic [NCH*SW-1:0]     smp_i,
  output logic [NCH*CODE_W-1:0] gain_o
);
  vol_reg_t [NCH-1:0] hold_nx;
  logic               commit;

  vol_hold #(.NCH(NCH)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .hold_nx_o (hold_nx),
    .commit_o  (commit)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    vol_chan #(.TMO(TMO)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .commit_i (commit),
      .nxt_i    (hold_nx[k]),
      .stb_i    (smp_stb_i),
      .sign_i   (smp_i[k*SW+SW-1]),
      .gain_o   (gain_o[k*CODE_W +: CODE_W])
    );
  end
endmodule

// File: tb/tb_vol_bank.sv
module tb_vol_bank;
  localparam int NCH = 6, SW = 16, TMO = 1024;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, stb = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [8:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [NCH*SW-1:0] smp = '0;
  logic [NCH*7-1:0] gain;

  vol_bank #(.NCH(NCH), .SW(SW), .TMO(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .smp_stb_i(stb), .smp_i(smp), .gain_o(gain));

  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 0;

  logic [7:0] m_hold [NCH];
  logic [6:0] m_gain [NCH];
  logic [6:0] m_pcode [NCH];
  bit         m_pend [NCH];
  bit         m_prev [NCH];
  int         m_cnt [NCH];

  task automatic chk(string req, int act, int exp, string what);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int k = 0; k < NCH; k++)
      chk(req, gain[k*7 +: 7], m_gain[k], $sformatf("gain ch%0d", k));
    for (int a = 0; a < 32; a++) begin
      rd_addr = a[4:0];
      #1;
      chk(req, rd_data, (a < NCH) ? m_hold[a] : 0, $sformatf("read addr %0d", a));
    end
  endtask

  task automatic wr(input int addr, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = addr[4:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (addr < NCH) begin
      m_hold[addr] = d[7:0];
      if (d[8])
        for (int k = 0; k < NCH; k++) begin
          if (m_hold[k][7]) begin
            m_pend[k] = 1; m_pcode[k] = m_hold[k][6:0]; m_cnt[k] = 0;
          end else begin
            m_gain[k] = m_hold[k][6:0]; m_pend[k] = 0;
          end
        end
    end
  endtask

  task automatic strobe(input logic [NCH-1:0] signs);
    @(negedge clk);
    for (int k = 0; k < NCH; k++)
      smp[k*SW +: SW] = signs[k] ? 16'hF0A5 : 16'h0A5F;
    stb = 1;
    @(negedge clk);
    stb = 0;
    for (int k = 0; k < NCH; k++) begin
      if (m_pend[k]) begin
        if (signs[k] != m_prev[k] || m_cnt[k] == TMO - 1) begin
          m_gain[k] = m_pcode[k]; m_pend[k] = 0;
        end else m_cnt[k]++;
      end
      m_prev[k] = signs[k];
    end
  endtask

  task automatic strobe_chk(input logic [NCH-1:0] signs, string req);
    strobe(signs);
    for (int k = 0; k < NCH; k++)
      chk(req, gain[k*7 +: 7], m_gain[k], $sformatf("gain ch%0d", k));
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin
      m_hold[k] = 8'h7F; m_gain[k] = 7'd127; m_pcode[k] = 7'd127;
      m_pend[k] = 0; m_prev[k] = 0; m_cnt[k] = 0;
    end
    #23 rst_n = 1;
    @(negedge clk);
    chk_all("R1");

    // R2 R3 R8: uncommitted writes over every address
    for (int a = 0; a < 32; a++) begin
      wr(a, {1'b0, 1'b0, 7'((a * 37 + 5) & 127)});
      chk_all((a < NCH) ? "R2" : "R8");
    end
    // R8: commit to unmapped address does nothing
    wr(9, 9'h155);
    chk_all("R8");
    // R4 R3: commit copies all channels
    wr(2, 9'h100 | 9'd33);
    chk_all("R4");
    // R5: later plain write does not commit
    wr(4, 9'd90);
    chk_all("R5");
    // R4 sweep of every code on rotating channels
    for (int c = 0; c < 128; c++) begin
      wr(c % NCH, {1'b1, 1'b0, 7'(c)});
      chk_all("R3");
    end

    // R6: zero-cross on ch1
    strobe_chk(6'b000000, "R6");
    wr(1, {1'b1, 1'b1, 7'd10});
    chk_all("R6");
    for (int i = 0; i < 5; i++) strobe_chk(6'b000000, "R6");
    strobe_chk(6'b000010, "R6");
    chk_all("R6");

    // R7: timeout on ch3, ch1 zc still set
    wr(3, {1'b1, 1'b1, 7'd55});
    for (int i = 0; i < TMO + 2; i++) strobe_chk(6'b000010, "R7");
    chk_all("R7");

    // R9: replacement restarts timeout
    wr(1, {1'b0, 1'b1, 7'd20});
    wr(3, {1'b1, 1'b1, 7'd21});
    for (int i = 0; i < 600; i++) strobe_chk(6'b000010, "R9");
    wr(1, {1'b1, 1'b1, 7'd77});
    for (int i = 0; i < 600; i++) strobe_chk(6'b000010, "R9");
    strobe_chk(6'b000000, "R9");
    chk_all("R9");

    // R10: non-zc commit cancels pending
    wr(5, {1'b1, 1'b1, 7'd3});
    wr(5, {1'b1, 1'b0, 7'd4});
    chk_all("R10");
    for (int i = 0; i < 4; i++) strobe_chk(6'b100000 ^ 6'(i << 5), "R10");
    chk_all("R10");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule